// File: doc/BRIEF.md
# Sync-Timed Video Mode Latch

This block holds a display mode that the processor may write at any moment, but it only applies that mode at a fixed point inside horizontal sync. Because the change lands while the beam is blanked, every visible line is drawn in one mode. The block outputs the active mode, the pixel clock divider that goes with it, and a one-cycle pulse that tells downstream logic to rebuild its mode-dependent tables.

A counter records how many consecutive clock edges have seen `hsync_i` high. It is cleared while sync is low and stops counting once it passes the latch point, so a long sync cannot produce a second latch. The pending mode is copied to the active mode on the fourth consecutive edge with sync high, but only if the two values differ. A write has no handshake: a pulse on `mode_wr_i` is always accepted, and the most recent value wins.

Top module: `vid_mode_latch`

## Requirements
- R1: While `rst_ni` is low and after it rises, `mode_o` is 0, `pix_div_o` is 4, `mode_chg_o` is 0, and the pending mode is 0.
- R2: The active mode takes the pending mode value at the clock edge where `hsync_i` is sampled high for the fourth consecutive time (parameter `LATCH_AT`).
- R3: If `hsync_i` falls before its fourth consecutive high sample, the active mode is unchanged on that line.
- R4: When the pending mode equals the active mode at the latch point, neither `mode_o` changes nor `mode_chg_o` pulses.
- R5: `pix_div_o` follows `mode_o` in the same cycle: mode 0 gives 4, mode 1 gives 2, mode 2 gives 1, and mode 3 gives 4.
- R6: `mode_chg_o` is high for exactly the one cycle that starts at the edge where `mode_o` takes a new value, and is low at all other times.
- R7: At most one latch occurs for each high period of `hsync_i`, however long it lasts. A mode written after the latch point waits for the next sync.
- R8: A write sampled on the first, second or third high edge of a sync is applied on that same line. A write sampled on the fourth high edge or later is not.
- R9: A write updates the pending mode on the edge where `mode_wr_i` is high. When several writes come before a latch, only the last one is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| hsync_i | input | 1 | Horizontal sync level, active high |
| mode_wr_i | input | 1 | Pending-mode write strobe |
| mode_wdata_i | input | MODE_W (2) | Value written to the pending mode |
| mode_o | output | MODE_W (2) | Active display mode |
| pix_div_o | output | DIV_W (3) | Pixel clock divider for the active mode |
| mode_chg_o | output | 1 | One-cycle pulse when the active mode changes |

## Verification
A write is visible to the latch from the edge after the one that samples it. The active mode, divider and change pulse all become valid in the cycle that follows the fourth consecutive high edge of `hsync_i`. The bench drives inputs on the falling clock edge and keeps a behavioural model that advances on each rising edge. It compares all three outputs at the next falling edge, before the new inputs are driven, so every comparison sees the values that the latest rising edge produced. Directed checks after each scenario confirm the line-level outcome: a short sync, a long sync, writes on either side of the latch point, repeated writes, and an unchanged mode.

// File: rtl/vml_pkg.sv
package vml_pkg;

  // Divider for a mode code; codes without their own entry use the slowest rate.
  function automatic int unsigned div_for_mode(input int unsigned mode);
    case (mode)
      1:       return 2;
      2:       return 1;
      default: return 4;
    endcase
  endfunction

endpackage

// File: rtl/vml_hsync_timer.sv
module vml_hsync_timer #(
  parameter int unsigned LATCH_AT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hsync_i,
  output logic latch_o
);
  localparam int unsigned CNT_W = $clog2(LATCH_AT + 1);
  localparam logic [CNT_W-1:0] SAT_VAL  = CNT_W'(LATCH_AT);
  localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(LATCH_AT - 1);

  logic [CNT_W-1:0] run_q;

  // Counts consecutive high samples and holds at SAT_VAL.
  always_ff @(posedge clk_i) begin
    if (!rst_ni)           run_q <= '0;
    else if (!hsync_i)     run_q <= '0;
    else if (run_q != SAT_VAL) run_q <= run_q + 1'b1;
  end

  // The current edge is the LATCH_AT-th consecutive high sample.
  assign latch_o = hsync_i && (run_q == PRE_LAST);

endmodule

// File: rtl/vml_mode_regs.sv
module vml_mode_regs #(
  parameter int unsigned MODE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              latch_i,
  input  logic              wr_i,
  input  logic [MODE_W-1:0] wdata_i,
  output logic [MODE_W-1:0] mode_o,
  output logic              load_o,
  output logic              chg_o
);
  logic [MODE_W-1:0] pend_q, act_q;
  logic              chg_q;

  // Load only when a latch point is reached and the value actually differs.
  assign load_o = latch_i && (pend_q != act_q);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      pend_q <= '0;
      act_q  <= '0;
      chg_q  <= 1'b0;
    end else begin
      if (wr_i)   pend_q <= wdata_i;
      if (load_o) act_q  <= pend_q;
      chg_q <= load_o;
    end
  end

  assign mode_o = act_q;
  assign chg_o  = chg_q;

endmodule

// File: rtl/vml_div_enc.sv
module vml_div_enc #(
  parameter int unsigned MODE_W = 2,
  parameter int unsigned DIV_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [MODE_W-1:0] next_mode_i,
  output logic [DIV_W-1:0]  div_o
);
  localparam int unsigned N_MODES = 1 << MODE_W;
  localparam logic [DIV_W-1:0] RST_DIV = DIV_W'(vml_pkg::div_for_mode(0));

  logic [DIV_W-1:0] div_tab [N_MODES];
  logic [DIV_W-1:0] div_q;

  for (genvar g = 0; g < N_MODES; g++) begin : g_tab
    assign div_tab[g] = DIV_W'(vml_pkg::div_for_mode(g));
  end

  // Registered together with the active mode so both move on the same edge.
  always_ff @(posedge clk_i) begin
    if (!rst_ni)     div_q <= RST_DIV;
    else if (load_i) div_q <= div_tab[next_mode_i];
  end

  assign div_o = div_q;

endmodule

// File: rtl/vid_mode_latch.sv
module vid_mode_latch #(
  parameter int unsigned MODE_W   = 2,
  parameter int unsigned DIV_W    = 3,
  parameter int unsigned LATCH_AT = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hsync_i,
  input  logic              mode_wr_i,
  input  logic [MODE_W-1:0] mode_wdata_i,
  output logic [MODE_W-1:0] mode_o,
  output logic [DIV_W-1:0]  pix_div_o,
  output logic              mode_chg_o
);
  logic              latch;
  logic              load;
  logic [MODE_W-1:0] pend_view;

  vml_hsync_timer #(.LATCH_AT(LATCH_AT)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hsync_i (hsync_i),
    .latch_o (latch)
  );

  vml_mode_regs #(.MODE_W(MODE_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .latch_i (latch),
    .wr_i    (mode_wr_i),
    .wdata_i (mode_wdata_i),
    .mode_o  (mode_o),
    .load_o  (load),
    .chg_o   (mode_chg_o)
  );

  // Pending value mirrored to the encoder so the divider loads with the mode.
  logic [MODE_W-1:0] pend_shadow_q;
  always_ff @(posedge clk_i) begin
    if (!rst_ni)        pend_shadow_q <= '0;
    else if (mode_wr_i) pend_shadow_q <= mode_wdata_i;
  end
  assign pend_view = pend_shadow_q;

  vml_div_enc #(.MODE_W(MODE_W), .DIV_W(DIV_W)) u_div (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .next_mode_i (pend_view),
    .div_o       (pix_div_o)
  );

endmodule

// File: rtl/vid_mode_latch_chk.sv
module vid_mode_latch_chk #(
  parameter int unsigned MODE_W = 2,
  parameter int unsigned DIV_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              hsync_i,
  input logic [MODE_W-1:0] mode_o,
  input logic [DIV_W-1:0]  pix_div_o,
  input logic              mode_chg_o
);
  // R1
  reset_state_chk: assert property (@(posedge clk_i)
    $past(!rst_ni) |-> (mode_o == '0 && pix_div_o == DIV_W'(4) && !mode_chg_o));

  // R5
  div_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_div_o == ((mode_o == MODE_W'(1)) ? DIV_W'(2) :
                  (mode_o == MODE_W'(2)) ? DIV_W'(1) : DIV_W'(4)));

  // R6
  chg_on_update_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != $past(mode_o)) |-> mode_chg_o);

  // R6
  chg_means_new_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_chg_o |-> (mode_o != $past(mode_o)));

  // R2
  chg_in_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_chg_o |-> $past(hsync_i));

  // R7
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_chg_o |=> !mode_chg_o);

endmodule

bind vid_mode_latch vid_mode_latch_chk #(.MODE_W(MODE_W), .DIV_W(DIV_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .hsync_i    (hsync_i),
  .mode_o     (mode_o),
  .pix_div_o  (pix_div_o),
  .mode_chg_o (mode_chg_o)
);

// File: tb/vid_mode_latch_tb_top.sv
module vid_mode_latch_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hs = 1'b0;
  logic       wr = 1'b0;
  logic [1:0] wd = 2'd0;
  logic [1:0] mode;
  logic [2:0] div;
  logic       chg;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  bit done = 1'b0;

  // reference model state
  int run = 0;
  int m_pend = 0;
  int m_act = 0;
  int m_chg = 0;

  always #5 clk = ~clk;

  vid_mode_latch dut_i (
    .clk_i(clk), .rst_ni(rst_n), .hsync_i(hs), .mode_wr_i(wr),
    .mode_wdata_i(wd), .mode_o(mode), .pix_div_o(div), .mode_chg_o(chg)
  );

  function automatic int exp_div(input int m);
    if (m == 1) return 2;
    if (m == 2) return 1;
    return 4;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      run = 0; m_pend = 0; m_act = 0; m_chg = 0;
    end else begin
      if (hs && run == 3 && m_pend != m_act) begin
        m_act = m_pend; m_chg = 1;
      end else m_chg = 0;
      if (wr) m_pend = wd;
      run = hs ? run + 1 : 0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic h, input logic w, input logic [1:0] d);
    @(negedge clk);
    check(int'(mode) == m_act, "R2 mode", int'(mode), m_act);
    check(int'(div) == exp_div(m_act), "R5 div", int'(div), exp_div(m_act));
    check(int'(chg) == m_chg, "R6 chg", int'(chg), m_chg);
    if (chg) pulses++;
    hs = h; wr = w; wd = d;
  endtask

  // hsync high for n edges, optional write sampled on high edge wr_at
  task automatic hline(input int n, input int wr_at, input logic [1:0] d);
    for (int i = 1; i <= n; i++) step(1'b1, i == wr_at, d);
    step(1'b0, 1'b0, 2'd0);
    step(1'b0, 1'b0, 2'd0);
    step(1'b0, 1'b0, 2'd0);
  endtask

  task automatic wr_idle(input logic [1:0] d);
    step(1'b0, 1'b1, d);
    step(1'b0, 1'b0, 2'd0);
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: values during reset
    check(mode == 2'd0 && div == 3'd4 && !chg, "R1 reset", int'(div), 4);
    rst_n = 1'b1;
    step(1'b0, 1'b0, 2'd0);
    check(mode == 2'd0 && div == 3'd4, "R1 after reset", int'(mode), 0);

    // R2 / R5: basic change to mode 1
    wr_idle(2'd1);
    hline(6, 0, 2'd0);
    check(mode == 2'd1, "R2 applied", int'(mode), 1);
    check(div == 3'd2, "R5 mode1 div", int'(div), 2);
    check(pulses == 1, "R6 one pulse", pulses, 1);

    // R3: sync too short
    wr_idle(2'd2);
    hline(3, 0, 2'd0);
    check(mode == 2'd1, "R3 short sync", int'(mode), 1);
    hline(8, 0, 2'd0);
    check(mode == 2'd2 && div == 3'd1, "R5 mode2 div", int'(div), 1);

    // R4: same value, no pulse
    pulses = 0;
    wr_idle(2'd2);
    hline(8, 0, 2'd0);
    check(pulses == 0, "R4 no pulse", pulses, 0);
    check(mode == 2'd2, "R4 mode held", int'(mode), 2);

    // R7: long sync, write after latch point waits
    hline(20, 10, 2'd0);
    check(mode == 2'd2, "R7 late write waits", int'(mode), 2);
    hline(6, 0, 2'd0);
    check(mode == 2'd0 && div == 3'd4, "R7 next line", int'(mode), 0);

    // R8: write on third high edge applies, fourth waits
    hline(6, 3, 2'd1);
    check(mode == 2'd1, "R8 early write", int'(mode), 1);
    hline(6, 4, 2'd2);
    check(mode == 2'd1, "R8 write at latch edge", int'(mode), 1);
    hline(6, 0, 2'd0);
    check(mode == 2'd2, "R8 applied next line", int'(mode), 2);

    // R5: mode 3
    wr_idle(2'd3);
    hline(5, 0, 2'd0);
    check(mode == 2'd3 && div == 3'd4, "R5 mode3 div", int'(div), 4);

    // R9: last write wins
    wr_idle(2'd1);
    wr_idle(2'd2);
    step(1'b0, 1'b1, 2'd0);
    hline(6, 0, 2'd0);
    check(mode == 2'd0, "R9 last write", int'(mode), 0);

    // R1: reset mid-run restores defaults
    wr_idle(2'd2);
    hline(6, 0, 2'd0);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(mode == 2'd0 && div == 3'd4 && !chg, "R1 re-reset", int'(mode), 0);
    rst_n = 1'b1;
    hline(6, 0, 2'd0);
    check(mode == 2'd0, "R1 pending cleared", int'(mode), 0);

    done = 1'b1;
    summary();
  end
endmodule